// File: doc/BRIEF.md
# Polled Interrupt Status Register

This block sits on the peripheral side of a software-polled interrupt scheme. A set of internal event sources, each conditioned as a rising edge or as a level, sets sticky "source" bits in one status register. While any bit is set, the block pulls a shared active-low request line toward the CPU. Its output is an open-drain style drive enable, so several devices can share the line as a wired-AND.

Polling software finds the requesting device by reading its status register over a small bus with chip select, read strobe and address. The read returns the bits as they stood before the read. The same read clears the bits it reported, which also withdraws the request. An event that arrives in the same cycle as the clearing read is kept, so no event is lost.

Top module: `polled_irq_stat`

## Requirements
- R1: After reset (rst_n low) every status bit is 0, irq_pull_o is 0 and a read returns 0.
- R2: A source whose bit in EDGE_MASK is 1 (default bits 0 and 1) sets its status bit on the clock edge after src_i goes from 0 to 1. Holding src_i high does not set the bit again once it has been cleared.
- R3: A source whose bit in EDGE_MASK is 0 (default bits 2 and 3) sets its status bit on every clock edge at which src_i is 1. A clearing read while the level is still high therefore leaves the bit set.
- R4: A set status bit stays set until a clearing read.
- R5: irq_pull_o is 1 exactly when at least one status bit is set. A value of 1 means the shared active-low request line is pulled low. A value of 0 means the line is released.
- R6: During a read hit (cs_i=1, rd_i=1, addr_i=REG_ADDR, default 4'h3), rdata_o shows status bit i on data bit i in the same cycle, with the value from before the clear. Data bits at or above NSRC read 0.
- R7: A read hit clears, at the next clock edge, every status bit it reported as 1. irq_pull_o falls at that edge if no bit remains set.
- R8: An event that occurs in the same cycle as a read hit leaves its status bit set after that edge. This holds whether or not the bit was already set.
- R9: An access with cs_i=0, with rd_i=0 or with addr_i not equal to REG_ADDR clears nothing, and rdata_o is 0 for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Internal event sources |
| cs_i | input | 1 | Chip select, active high |
| rd_i | input | 1 | Read strobe, active high |
| addr_i | input | AW | Register address |
| rdata_o | output | DW | Read data, 0 when not a read hit |
| irq_pull_o | output | 1 | 1 pulls the shared active-low request line low |

## Verification
Directed sequences first separate edge from level conditioning: a held edge source must not re-arm after its clear, while a held level source must survive a clearing read. Near-miss accesses come next: chip select low, strobe low and a wrong address must all read 0 and leave the request standing, which distinguishes a true read hit from a partial decode. Reads that coincide with a fresh event, on a clear bit and on a set bit, tell the pre-clear readback apart from the post-edge state. Long seeded random runs then mix source toggling with random accesses against a bench model of the status bits, to catch ordering errors between set and clear.

// File: rtl/polled_irq_pkg.sv
package polled_irq_pkg;

  // Conditioning of one source: edge mode fires on a 0->1 step only,
  // level mode fires whenever the source is high.
  function automatic logic cond_event(input logic lvl,
                                      input logic lvl_q,
                                      input logic edge_mode);
    return edge_mode ? (lvl & ~lvl_q) : lvl;
  endfunction

  // Next value of one sticky bit: a fresh event outranks a clear.
  function automatic logic bit_next(input logic cur,
                                    input logic ev,
                                    input logic clr);
    return ev | (cur & ~clr);
  endfunction

  // Address/strobe decode of a read hit.
  function automatic logic read_hit(input logic cs,
                                    input logic rd,
                                    input logic addr_match);
    return cs & rd & addr_match;
  endfunction

endpackage

// File: rtl/irq_evt_cond.sv
module irq_evt_cond
  import polled_irq_pkg::*;
#(
  parameter int          NSRC      = 4,
  parameter logic [NSRC-1:0] EDGE_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] evt_o
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic src_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src_i[i];
      end
      assign evt_o[i] = cond_event(src_i[i], src_q, 1'b1);
    end else begin : g_level
      assign evt_o[i] = cond_event(src_i[i], 1'b0, 1'b0);
    end
  end

endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
  import polled_irq_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] stat_o
);

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_o[i] <= 1'b0;
      else        stat_o[i] <= bit_next(stat_o[i], evt_i[i], clr_i[i]);
    end
  end

endmodule

// File: rtl/irq_bus_rd.sv
module irq_bus_rd
  import polled_irq_pkg::*;
#(
  parameter int          NSRC     = 4,
  parameter int          AW       = 4,
  parameter int          DW       = 8,
  parameter logic [AW-1:0] REG_ADDR = '0
) (
  input  logic            cs_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NSRC-1:0] stat_i,
  output logic            hit_o,
  output logic [NSRC-1:0] clr_o,
  output logic [DW-1:0]   rdata_o
);

  assign hit_o = read_hit(cs_i, rd_i, addr_i == REG_ADDR);
  assign clr_o = hit_o ? stat_i : '0;

  always_comb begin
    rdata_o = '0;
    if (hit_o) rdata_o[NSRC-1:0] = stat_i;
  end

endmodule

// File: rtl/polled_irq_stat.sv
module polled_irq_stat
#(
  parameter int          NSRC      = 4,
  parameter int          AW        = 4,
  parameter int          DW        = 8,
  parameter logic [AW-1:0] REG_ADDR  = 4'h3,
  parameter logic [NSRC-1:0] EDGE_MASK = 4'b0011
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            cs_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_pull_o
);

  logic [NSRC-1:0] evt_w;
  logic [NSRC-1:0] clr_w;
  logic [NSRC-1:0] stat_w;
  logic            rd_hit_w;

  irq_evt_cond #(.NSRC(NSRC), .EDGE_MASK(EDGE_MASK)) u_cond (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .evt_o (evt_w)
  );

  irq_stat_reg #(.NSRC(NSRC)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_w),
    .clr_i  (clr_w),
    .stat_o (stat_w)
  );

  irq_bus_rd #(.NSRC(NSRC), .AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) u_rd (
    .cs_i    (cs_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .stat_i  (stat_w),
    .hit_o   (rd_hit_w),
    .clr_o   (clr_w),
    .rdata_o (rdata_o)
  );

  // Drive enable of the shared active-low line.
  assign irq_pull_o = |stat_w;

endmodule

// File: rtl/polled_irq_stat_chk.sv
module polled_irq_stat_chk #(
  parameter int NSRC = 4,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_i,
  input logic            rd_i,
  input logic [NSRC-1:0] evt_w,
  input logic [NSRC-1:0] stat_w,
  input logic            rd_hit_w,
  input logic [DW-1:0]   rdata_o,
  input logic            irq_pull_o
);

  // R8: an event is never lost, even against a clearing read
  p_event_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_w != '0) |=> ((stat_w & $past(evt_w)) == $past(evt_w)));

  // R4: without a read hit no bit drops
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit_w |=> ((stat_w & $past(stat_w)) == $past(stat_w)));

  // R7: a read hit with no new event empties the register
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit_w && evt_w == '0) |=> (stat_w == '0));

  // R5: the request only rises after some event
  p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pull_o |=> (!irq_pull_o || $past(evt_w) != '0));

  // R9: no strobe or no select means quiet data bus
  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_i && rd_i) |-> (rdata_o == '0));

  // R6: data bits above the sources always read zero
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata_o >> NSRC) == '0));

endmodule

bind polled_irq_stat polled_irq_stat_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_i       (cs_i),
  .rd_i       (rd_i),
  .evt_w      (evt_w),
  .stat_w     (stat_w),
  .rd_hit_w   (rd_hit_w),
  .rdata_o    (rdata_o),
  .irq_pull_o (irq_pull_o)
);

// File: tb/sim_polled_irq_stat.sv
module sim_polled_irq_stat;
  localparam int CLK_P = 10;
  localparam int NSRC = 4;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] RADDR = 4'h3;
  localparam logic [NSRC-1:0] EMASK = 4'b0011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic cs = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] rdata;
  logic pull;

  int checks = 0;
  int errors = 0;

  logic [NSRC-1:0] m_stat = '0;
  logic [NSRC-1:0] m_prev = '0;
  logic [DW-1:0] got_rdata;
  logic got_pull;

  always #(CLK_P/2) clk = ~clk;

  polled_irq_stat u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .cs_i(cs), .rd_i(rd),
    .addr_i(addr), .rdata_o(rdata), .irq_pull_o(pull)
  );

  function automatic logic [NSRC-1:0] exp_events(input logic [NSRC-1:0] s,
                                                 input logic [NSRC-1:0] p);
    logic [NSRC-1:0] e;
    for (int i = 0; i < NSRC; i++)
      e[i] = EMASK[i] ? (s[i] && !p[i]) : s[i];
    return e;
  endfunction

  function automatic logic [NSRC-1:0] exp_next(input logic [NSRC-1:0] st,
                                               input logic [NSRC-1:0] ev,
                                               input logic hit);
    return hit ? ev : (st | ev);
  endfunction

  function automatic logic [DW-1:0] exp_rdata(input logic [NSRC-1:0] st,
                                              input logic hit);
    logic [DW-1:0] d = '0;
    if (hit) d[NSRC-1:0] = st;
    return d;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, compare against model, advance model.
  task automatic step(input logic [NSRC-1:0] s, input logic c, input logic r,
                      input logic [AW-1:0] a, input string tag);
    logic hit;
    @(negedge clk);
    src = s; cs = c; rd = r; addr = a;
    #1;
    hit = c && r && (a == RADDR);
    got_rdata = rdata;
    got_pull = pull;
    chk({tag, hit ? " R6 rdata" : " R9 rdata"}, rdata, exp_rdata(m_stat, hit));
    chk({tag, " R5 pull"}, {7'd0, pull}, {7'd0, (m_stat != '0)});
    @(posedge clk);
    if (rst_n) begin
      m_stat = exp_next(m_stat, exp_events(s, m_prev), hit);
      m_prev = s;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (2) step(4'b0000, 1'b1, 1'b1, RADDR, "R1");
    @(negedge clk); rst_n = 1'b1;
    step(4'b0000, 1'b1, 1'b1, RADDR, "R1");
    chk("R1 read after reset", got_rdata, 8'h00);
    chk("R1 pull after reset", {7'd0, got_pull}, 8'h00);

    // R2: edge source
    step(4'b0001, 1'b0, 1'b0, '0, "R2");
    step(4'b0001, 1'b0, 1'b0, '0, "R2");
    chk("R2 pull after edge", {7'd0, got_pull}, 8'h01);
    step(4'b0001, 1'b1, 1'b1, RADDR, "R2");
    chk("R2 read edge bit", got_rdata, 8'h01);
    step(4'b0001, 1'b1, 1'b1, RADDR, "R7");
    chk("R7 cleared bit", got_rdata, 8'h00);
    chk("R7 pull dropped", {7'd0, got_pull}, 8'h00);
    step(4'b0001, 1'b1, 1'b1, RADDR, "R2");
    chk("R2 held high no rearm", got_rdata, 8'h00);

    // R3: level source survives a read while high
    step(4'b0100, 1'b0, 1'b0, '0, "R3");
    step(4'b0100, 1'b1, 1'b1, RADDR, "R3");
    chk("R3 level read", got_rdata, 8'h04);
    step(4'b0000, 1'b1, 1'b1, RADDR, "R3");
    chk("R3 still set after read", got_rdata, 8'h04);
    step(4'b0000, 1'b1, 1'b1, RADDR, "R3");
    chk("R3 cleared after release", got_rdata, 8'h00);

    // R9 and R4: near-miss accesses leave bit 1 set
    step(4'b0010, 1'b0, 1'b0, '0, "R9");
    step(4'b0000, 1'b0, 1'b1, RADDR, "R9");
    chk("R9 cs low", got_rdata, 8'h00);
    step(4'b0000, 1'b1, 1'b0, RADDR, "R9");
    chk("R9 rd low", got_rdata, 8'h00);
    step(4'b0000, 1'b1, 1'b1, 4'h2, "R9");
    chk("R9 wrong addr", got_rdata, 8'h00);
    chk("R4 pull holds", {7'd0, got_pull}, 8'h01);
    step(4'b0000, 1'b1, 1'b1, RADDR, "R4");
    chk("R4 bit survived", got_rdata, 8'h02);

    // R8: event coinciding with a read hit
    step(4'b0001, 1'b1, 1'b1, RADDR, "R8");
    chk("R8 pre-clear value", got_rdata, 8'h00);
    step(4'b0000, 1'b1, 1'b1, RADDR, "R8");
    chk("R8 event kept on clear bit", got_rdata, 8'h01);
    step(4'b0000, 1'b0, 1'b0, '0, "R8");
    step(4'b0010, 1'b0, 1'b0, '0, "R8");
    step(4'b0000, 1'b0, 1'b0, '0, "R8");
    step(4'b0010, 1'b1, 1'b1, RADDR, "R8");
    chk("R8 read set bit", got_rdata, 8'h02);
    step(4'b0000, 1'b1, 1'b1, RADDR, "R8");
    chk("R8 event kept on set bit", got_rdata, 8'h02);

    // Random mix against the model
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      a = ($urandom % 3 == 0) ? RADDR : AW'($urandom);
      step(NSRC'($urandom), ($urandom % 4) != 0, ($urandom % 2) != 0, a, "RND");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule